// File: doc/BRIEF.md
# Multiphase Pulsed-Latch Shift Register

This block is a serial-in, serial-out shift register. Its length is set by chaining a configurable number of sub-blocks, each four stages wide, with one single-element store per bit rather than a master/slave pair. A phase sequencer turns every accepted shift request into a run of narrow, one-cycle enable strobes, one per stage. The strobes fire one at a time, starting at the stage nearest the output and working back toward the input. Each stage therefore opens only after its downstream neighbour has already taken the old value. Because of this, a bit advances exactly one stage per shift, and no two neighbouring stages are ever open in the same cycle.

Each strobe is formed by an edge detector: a per-stage window level is ANDed with an inverted, one-cycle-delayed copy of itself. This gives one narrow high slot when the window opens. The last stage of each sub-block drives a terminal link that feeds the first stage of the next sub-block. All stage contents are brought out for observation, and a busy flag marks the strobe sequence.

Top module: `pl_shift_chain`

## Requirements
- R1: While rst_ni is low, every stage reads 0 and busy_o is 0. This holds immediately, even in the middle of a shift.
- R2: While busy_o is 0, a high shift_req_i at a rising clock edge sets busy_o on that edge. busy_o then stays high for exactly N = 4*NUM_GROUPS cycles.
- R3: A shift request seen while busy_o is 1 is ignored. It neither lengthens the busy window nor causes a second shift.
- R4: Each busy cycle opens exactly one stage, in descending index order from stage N-1 to stage 0. No stage opens while idle.
- R5: Two neighbouring stages are never open in the same cycle, and each stage opens once per shift.
- R6: In a shift, stage k (k ≥ 1) takes the value stage k-1 held before that shift. Stage 0 takes serial_i as sampled on the edge that ends the last busy cycle.
- R7: Data crosses from stage 3 of one sub-block into stage 0 of the next sub-block through the terminal link, one stage per shift.
- R8: serial_o equals stage N-1. It changes only on the edge that ends the first busy cycle of a shift.
- R9: When a shift ends, stages_o equals a flip-flop reference register shifted once with the sampled input. For example, the input pattern 1,0,1,0 fed into a cleared register gives stages_o[3:0] = 4'b1010.
- R10: stages_o bit k is stage k, where stage 0 is nearest serial_i. Stage contents do not change while busy_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock from which all phase strobes are derived |
| rst_ni | input | 1 | Asynchronous active-low reset |
| shift_req_i | input | 1 | Shift request, taken only while idle |
| serial_i | input | 1 | Serial data into stage 0 |
| serial_o | output | 1 | Serial data out of stage N-1 |
| busy_o | output | 1 | High while a strobe sequence is running |
| stages_o | output | 4*NUM_GROUPS | Observed contents of every stage, bit k = stage k |

## Verification
The hardest situations to reach are the ones where the inputs move while the strobe sequence is still running. These are a request held high or re-pulsed partway through a shift, serial_i toggling on every busy cycle, and reset dropping between two phases. The stimulus drives each of these on purpose. A cycle-accurate model then predicts which stages have already taken the new data in each cycle. Pattern shifts that carry data across the sub-block boundary confirm the terminal link.

// File: rtl/pl_shift_pkg.sv
package pl_shift_pkg;
  localparam int unsigned GROUP_W_DEF = 4;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/pl_latch_stage.sv
module pl_latch_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic open_i,
  input  logic d_i,
  output logic q_o
);
  // single store per bit, transparent only during its strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (open_i) q_o <= d_i;
  end
endmodule

// File: rtl/pl_sub_block.sv
module pl_sub_block #(
  parameter int unsigned GROUP_W = pl_shift_pkg::GROUP_W_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               term_i,
  input  logic [GROUP_W-1:0] open_i,
  output logic [GROUP_W-1:0] q_o,
  output logic               term_o
);
  logic [GROUP_W:0] chain;

  assign chain[0] = term_i;

  for (genvar k = 0; k < GROUP_W; k++) begin : g_stage
    pl_latch_stage i_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .open_i (open_i[k]),
      .d_i    (chain[k]),
      .q_o    (chain[k+1])
    );
  end

  assign q_o    = chain[GROUP_W:1];
  assign term_o = chain[GROUP_W];
endmodule

// File: rtl/pl_phase_seq.sv
module pl_phase_seq #(
  parameter int unsigned N_STAGES = 8,
  parameter int unsigned CNT_W    = $clog2(N_STAGES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  output logic             busy_o,
  output logic [CNT_W-1:0] cnt_o
);
  import pl_shift_pkg::*;

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (req_i) begin
          state_q <= SEQ_RUN;
          cnt_q   <= CNT_W'(N_STAGES - 1);
        end
        SEQ_RUN: begin
          if (cnt_q == '0) state_q <= SEQ_IDLE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q == SEQ_RUN);
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/pl_pulse_former.sv
module pl_pulse_former #(
  parameter int unsigned N_STAGES = 8,
  parameter int unsigned CNT_W    = $clog2(N_STAGES)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                busy_i,
  input  logic [CNT_W-1:0]    cnt_i,
  output logic [N_STAGES-1:0] phase_o
);
  logic [N_STAGES-1:0] win;
  logic [N_STAGES-1:0] win_q;

  for (genvar k = 0; k < N_STAGES; k++) begin : g_phase
    // window opens when the countdown reaches k and stays open to the end
    assign win[k]     = busy_i && (cnt_i <= CNT_W'(k));
    // narrow strobe: window AND inverted delayed window
    assign phase_o[k] = win[k] & ~win_q[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) win_q <= '0;
    else         win_q <= win;
  end
endmodule

// File: rtl/pl_shift_chain.sv
module pl_shift_chain #(
  parameter int unsigned NUM_GROUPS = 2,
  parameter int unsigned GROUP_W    = pl_shift_pkg::GROUP_W_DEF
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          shift_req_i,
  input  logic                          serial_i,
  output logic                          serial_o,
  output logic                          busy_o,
  output logic [NUM_GROUPS*GROUP_W-1:0] stages_o
);
  localparam int unsigned N_STAGES = NUM_GROUPS * GROUP_W;
  localparam int unsigned CNT_W    = $clog2(N_STAGES);

  logic [CNT_W-1:0]    cnt_w;
  logic [N_STAGES-1:0] phase_w;
  logic [NUM_GROUPS:0] link_w;

  pl_phase_seq #(.N_STAGES(N_STAGES), .CNT_W(CNT_W)) i_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (shift_req_i),
    .busy_o (busy_o),
    .cnt_o  (cnt_w)
  );

  pl_pulse_former #(.N_STAGES(N_STAGES), .CNT_W(CNT_W)) i_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .busy_i  (busy_o),
    .cnt_i   (cnt_w),
    .phase_o (phase_w)
  );

  assign link_w[0] = serial_i;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    pl_sub_block #(.GROUP_W(GROUP_W)) i_sub (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .term_i (link_w[g]),
      .open_i (phase_w[g*GROUP_W +: GROUP_W]),
      .q_o    (stages_o[g*GROUP_W +: GROUP_W]),
      .term_o (link_w[g+1])
    );
  end

  assign serial_o = link_w[NUM_GROUPS];
endmodule

// File: rtl/pl_shift_chain_chk.sv
module pl_shift_chain_chk #(
  parameter int unsigned NUM_GROUPS = 2,
  parameter int unsigned GROUP_W    = 4,
  localparam int unsigned N = NUM_GROUPS * GROUP_W
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         shift_req_i,
  input logic         busy_i,
  input logic         serial_o_i,
  input logic [N-1:0] stages_i,
  input logic [N-1:0] phase_i
);
  p_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && shift_req_i) |=> busy_i);

  p_end_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && phase_i[0]) |=> !busy_i);

  p_no_extend_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !phase_i[0]) |=> busy_i);

  p_one_phase_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> ($countones(phase_i) == 1));

  p_idle_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (phase_i == '0));

  p_first_phase_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> phase_i[N-1]);

  p_descend_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !phase_i[0]) |=> (phase_i == ($past(phase_i) >> 1)));

  p_serial_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phase_i[N-1] |=> $stable(serial_o_i));

  p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> $stable(stages_i));

  for (genvar k = 1; k < N; k++) begin : g_cap
    p_capture_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      phase_i[k] |=> (stages_i[k] == $past(stages_i[k-1])));
  end
endmodule

bind pl_shift_chain pl_shift_chain_chk #(
  .NUM_GROUPS (NUM_GROUPS),
  .GROUP_W    (GROUP_W)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .shift_req_i (shift_req_i),
  .busy_i      (busy_o),
  .serial_o_i  (serial_o),
  .stages_i    (stages_o),
  .phase_i     (phase_w)
);

// File: tb/test_pl_shift_chain.sv
module test_pl_shift_chain;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_GROUPS = 2;
  localparam int GROUP_W    = 4;
  localparam int N          = NUM_GROUPS * GROUP_W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         shift_req = 1'b0;
  logic         serial_in = 1'b0;
  logic         serial_out;
  logic         busy;
  logic [N-1:0] stages;

  int n_checks = 0;
  int n_errors = 0;
  bit cmp_en   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pl_shift_chain #(.NUM_GROUPS(NUM_GROUPS), .GROUP_W(GROUP_W)) i_pl_shift_chain (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .shift_req_i (shift_req),
    .serial_i    (serial_in),
    .serial_o    (serial_out),
    .busy_o      (busy),
    .stages_o    (stages)
  );

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", what, act, exp, $time);
    end
  endtask

  // behavioural reference: remaining phases plus snapshot of pre-shift contents
  int           m_left = 0;
  logic [N-1:0] m_q    = '0;
  logic [N-1:0] m_snap = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_left = 0;
      m_q    = '0;
    end else if (m_left == 0) begin
      if (shift_req) begin
        m_left = N;
        m_snap = m_q;
      end
    end else begin
      int k;
      k = m_left - 1;
      m_q[k] = (k == 0) ? serial_in : m_snap[k-1];
      m_left--;
    end
  end

  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      chk("R2 R3 busy window", 32'(busy), 32'(m_left != 0));
      chk("R4 R5 R6 stage contents", 32'(stages), 32'(m_q));
      chk("R8 R10 serial_o", 32'(serial_out), 32'(m_q[N-1]));
    end
  end

  logic [N-1:0] gold = '0;

  task automatic do_shift(input logic b, output int busy_cycles);
    serial_in = b;
    shift_req = 1'b1;
    @(negedge clk);
    shift_req   = 1'b0;
    busy_cycles = 0;
    while (busy) begin
      busy_cycles++;
      @(negedge clk);
    end
    gold = {gold[N-2:0], b};
    chk("R9 flip-flop reference", 32'(stages), 32'(gold));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    int bc;
    repeat (3) @(negedge clk);
    chk("R1 reset stages", 32'(stages), 32'h0);
    chk("R1 reset busy", 32'(busy), 32'h0);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    @(negedge clk);

    // pattern 1,0,1,0
    do_shift(1'b1, bc);
    chk("R2 busy length", 32'(bc), 32'(N));
    do_shift(1'b0, bc);
    do_shift(1'b1, bc);
    do_shift(1'b0, bc);
    chk("R9 pattern 1010", 32'(stages[3:0]), 32'hA);
    for (int i = 0; i < 4; i++) do_shift(1'b0, bc);
    chk("R7 across boundary", 32'(stages[7:4]), 32'hA);
    chk("R8 serial tap", 32'(serial_out), 32'h1);

    // request re-pulsed while busy must be ignored
    serial_in = 1'b1;
    shift_req = 1'b1;
    @(negedge clk);
    shift_req = 1'b0;
    bc = 0;
    while (busy) begin
      bc++;
      if (bc == 3) shift_req = 1'b1;
      if (bc == 5) shift_req = 1'b0;
      @(negedge clk);
    end
    shift_req = 1'b0;
    gold = {gold[N-2:0], 1'b1};
    chk("R3 busy not extended", 32'(bc), 32'(N));
    repeat (2) @(negedge clk);
    chk("R3 no second shift", 32'(stages), 32'(gold));
    chk("R3 idle after", 32'(busy), 32'h0);

    // request held high: back-to-back shifts, one idle cycle between
    shift_req = 1'b1;
    serial_in = 1'b1;
    repeat (3 * (N + 1)) @(negedge clk);
    shift_req = 1'b0;
    while (busy) @(negedge clk);

    // serial input toggling on every busy cycle
    for (int s = 0; s < 12; s++) begin
      shift_req = 1'b1;
      serial_in = 1'($urandom);
      @(negedge clk);
      shift_req = 1'b0;
      while (busy) begin
        serial_in = 1'($urandom);
        @(negedge clk);
      end
    end

    // reset in the middle of a shift
    serial_in = 1'b1;
    shift_req = 1'b1;
    @(negedge clk);
    shift_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 mid-shift reset stages", 32'(stages), 32'h0);
    chk("R1 mid-shift reset busy", 32'(busy), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    gold = '0;
    @(negedge clk);
    do_shift(1'b1, bc);
    chk("R2 busy length after reset", 32'(bc), 32'(N));

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule